// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block gives a processor indirect access to the configuration registers of a small, fixed set of on-chip devices through two four-byte windows in I/O space. One window latches a configuration address. The other window carries the data. Software first writes the address, which gives the bus, device and function of the target and a dword index. Writing the most significant byte of the address window starts a lookup. The lookup finds out whether the selected function exists, and it loads a response register and a status register from the result. Reads of the data window return bytes of the response register. Reads of the address window return bytes of the status register.

Writes to the data window go straight into the configuration dwords of the selected function. They use byte lanes, so an 8-bit, 16-bit or 32-bit store updates only the bytes it covers. Such a write does not refresh the response register: the new value becomes readable only after the next lookup. Each function in the table has its own 16-bit bus/device/function code, which is fixed by a parameter. Each function implements a parameterised number of dwords, and the first of them resets to an identity value.

The lookup is a three-state machine. IDLE waits for a write that covers the top address byte; that event is the *trigger* transition, IDLE→MATCH. In MATCH the latched code is compared against the table and the result is registered (transition *compared*, MATCH→FETCH). In FETCH the response and status registers are loaded (transition *loaded*, FETCH→IDLE). The bus must not issue any access while `busy` is high.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the response and status registers read as zero, `busy` and `cfg_err` are low, and every function's dword 0 holds its identity value while its other dwords hold zero.
- R2: In the latched address, bits 23:16 are the bus, 15:11 the device and 10:8 the function, and together these 16 bits must equal a table entry for the function to count as present. Bits 7:2 are the dword index. Bits 31:24, including the enable bit 31, do not affect the lookup, and bits 1:0 always latch as zero.
- R3: A lookup starts only on a legal write that covers byte 3 of the address window. Writes that cover only bytes 0 to 2 update the latched address and leave the response and status unchanged.
- R4: `busy` is high for exactly two clock cycles after the edge that accepts the triggering write. The results are readable once it falls.
- R5: If the function is present and the dword index is below the implemented count, the status becomes 0x80000000 and the response becomes that dword.
- R6: If the function is present and the dword index is at or above the implemented count, the response becomes 0 and the status becomes 0x80000000.
- R7: If the function is absent, the response becomes 0xFFFFFFFF and the status becomes 0.
- R8: Reads are combinational. The lane n is I/O address bits 1:0, and `io_size` is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. A read returns the register starting at byte n, right-justified, with the bits above the access size zero. The data window returns the response and the address window returns the status. Any other I/O address reads as 0, and writes to it have no effect.
- R9: A data-window write at lane n stores its bytes into byte n and up of the addressed dword of the selected function. The write does not change the response until the next lookup.
- R10: A 16-bit write at lane 1 or 3, a 32-bit write at any lane other than 0, or a write with size code 3 is dropped in either window. It sets `cfg_err`, which stays set until reset.
- R11: A data-window write to an absent function, or to a dword index at or above the implemented count, changes no stored dword and does not set `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe for one cycle |
| io_addr | input | 16 | I/O byte address of the access |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| io_wdata | input | 32 | Write data, right-justified |
| io_rdata | output | 32 | Read data for the current address and size |
| busy | output | 1 | Lookup in progress; no access allowed |
| cfg_err | output | 1 | Sticky flag for a misaligned write |

## Verification
A wrong lookup state shows at the ports within three cycles of the trigger. It appears as a `busy` pulse of the wrong length, or as a response and status pair that disagrees with the table, such as all ones together with a set status bit. A corrupted latched address or a stray store is silent until the next lookup. For that reason the stimulus re-triggers a lookup after every data write and after every ignored write, and then reads the window. A dropped misaligned write shows at once on `cfg_err`, and its lack of effect shows one lookup later.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MATCH = 2'd1,
        ST_FETCH = 2'd2
    } lk_state_e;

    localparam logic [31:0] STATUS_FOUND = 32'h8000_0000;
    localparam logic [31:0] RESP_ABSENT  = 32'hFFFF_FFFF;

    // Legal size/lane pairs: byte anywhere, word at 0 or 2, dword at 0.
    function automatic logic access_legal(input logic [1:0] sz, input logic [1:0] lane);
        logic ok;
        unique case (sz)
            2'd0:    ok = 1'b1;
            2'd1:    ok = (lane[0] == 1'b0);
            2'd2:    ok = (lane == 2'd0);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [3:0] lane_enables(input logic [1:0] sz, input logic [1:0] lane);
        logic [3:0] base;
        unique case (sz)
            2'd0:    base = 4'b0001;
            2'd1:    base = 4'b0011;
            default: base = 4'b1111;
        endcase
        return base << lane;
    endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [3:0]  be,
    input  logic [23:0] wdata,
    output logic [15:0] bdf,
    output logic [5:0]  dword_idx,
    output logic        fire
);
    logic [5:0] reg_q;
    logic [7:0] lo_q;
    logic [7:0] hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (we) begin
            if (be[0]) reg_q <= wdata[7:2];
            if (be[1]) lo_q  <= wdata[15:8];
            if (be[2]) hi_q  <= wdata[23:16];
        end
    end

    // Byte 3 carries no stored field; covering it only starts a lookup.
    assign fire      = we && be[3];
    assign bdf       = {hi_q, lo_q};
    assign dword_idx = reg_q;

    assert_partial_keeps_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !be[2]) |=> (bdf[15:8] == $past(bdf[15:8])));

endmodule

// File: rtl/cfg_dev_match.sv
module cfg_dev_match #(
    parameter int unsigned                NUM_DEV = 2,
    parameter int unsigned                IDX_W   = 1,
    parameter logic [NUM_DEV*16-1:0]      DEV_BDF = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      bdf,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [NUM_DEV-1:0] eq;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_cmp
        assign eq[g] = (bdf == DEV_BDF[g*16 +: 16]);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |eq;

    assert_unique_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eq));

endmodule

// File: rtl/cfg_space_store.sv
module cfg_space_store #(
    parameter int unsigned           NUM_DEV     = 2,
    parameter int unsigned           IMPL_DWORDS = 16,
    parameter int unsigned           IDX_W       = 1,
    parameter int unsigned           DW_W        = 4,
    parameter logic [NUM_DEV*32-1:0] DEV_ID      = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wdev,
    input  logic [DW_W-1:0]  wdw,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] rdev,
    input  logic [DW_W-1:0]  rdw,
    output logic [31:0]      rdata
);
    logic [31:0] mem [NUM_DEV][IMPL_DWORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < NUM_DEV; d++) begin
                for (int w = 0; w < IMPL_DWORDS; w++) begin
                    mem[d][w] <= (w == 0) ? DEV_ID[d*32 +: 32] : 32'h0;
                end
            end
        end else if (we) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) mem[wdev][wdw][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    assign rdata = mem[rdev][rdw];

    assert_write_has_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (be != 4'b0000));

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
    import cfg_port_pkg::*;
#(
    parameter logic [15:0]           ADDR_PORT   = 16'h0CF8,
    parameter logic [15:0]           DATA_PORT   = 16'h0CFC,
    parameter int unsigned           NUM_DEV     = 2,
    parameter int unsigned           IMPL_DWORDS = 16,
    parameter logic [NUM_DEV*16-1:0] DEV_BDF     = {16'h0008, 16'h0000},
    parameter logic [NUM_DEV*32-1:0] DEV_ID      = {32'h5678_9ABC, 32'h1234_ABCD}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_wr,
    input  logic [15:0] io_addr,
    input  logic [1:0]  io_size,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        busy,
    output logic        cfg_err
);
    localparam int unsigned IDX_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int unsigned DW_W     = (IMPL_DWORDS > 1) ? $clog2(IMPL_DWORDS) : 1;
    localparam logic [6:0]  IMPL_LIM = 7'(IMPL_DWORDS);

    // Access decode
    logic [1:0]  lane;
    logic        sel_addr, sel_data, legal;
    logic [3:0]  be;
    logic [31:0] wsh;
    logic        wr_addr_ok, wr_data_ok, wr_bad;

    assign lane       = io_addr[1:0];
    assign sel_addr   = (io_addr[15:2] == ADDR_PORT[15:2]);
    assign sel_data   = (io_addr[15:2] == DATA_PORT[15:2]);
    assign legal      = access_legal(io_size, lane);
    assign be         = lane_enables(io_size, lane);
    assign wsh        = io_wdata << {lane, 3'b000};
    assign wr_addr_ok = io_wr && sel_addr && legal;
    assign wr_data_ok = io_wr && sel_data && legal;
    assign wr_bad     = io_wr && (sel_addr || sel_data) && !legal;

    // Address latch
    logic [15:0] bdf;
    logic [5:0]  dword_idx;
    logic        fire;

    cfg_addr_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_addr_ok),
        .be        (be),
        .wdata     (wsh[23:0]),
        .bdf       (bdf),
        .dword_idx (dword_idx),
        .fire      (fire)
    );

    // Presence check
    logic             hit;
    logic [IDX_W-1:0] idx;

    cfg_dev_match #(
        .NUM_DEV (NUM_DEV),
        .IDX_W   (IDX_W),
        .DEV_BDF (DEV_BDF)
    ) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .bdf   (bdf),
        .hit   (hit),
        .idx   (idx)
    );

    // Configuration storage
    logic             in_range;
    logic             store_we;
    logic             hit_q;
    logic [IDX_W-1:0] idx_q;
    logic [31:0]      store_rdata;

    assign in_range = ({1'b0, dword_idx} < IMPL_LIM);
    assign store_we = wr_data_ok && hit && in_range;

    cfg_space_store #(
        .NUM_DEV     (NUM_DEV),
        .IMPL_DWORDS (IMPL_DWORDS),
        .IDX_W       (IDX_W),
        .DW_W        (DW_W),
        .DEV_ID      (DEV_ID)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .wdev  (idx),
        .wdw   (dword_idx[DW_W-1:0]),
        .be    (be),
        .wdata (wsh),
        .rdev  (idx_q),
        .rdw   (dword_idx[DW_W-1:0]),
        .rdata (store_rdata)
    );

    // Lookup state machine
    lk_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (fire) state_nx = ST_MATCH;
            ST_MATCH: state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    logic [31:0] resp_q, status_q;
    logic        err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q    <= 1'b0;
            idx_q    <= '0;
            resp_q   <= '0;
            status_q <= '0;
            err_q    <= 1'b0;
        end else begin
            if (wr_bad) err_q <= 1'b1;
            unique case (state)
                ST_MATCH: begin
                    hit_q <= hit;
                    idx_q <= idx;
                end
                ST_FETCH: begin
                    if (!hit_q) begin
                        resp_q   <= RESP_ABSENT;
                        status_q <= '0;
                    end else begin
                        resp_q   <= in_range ? store_rdata : 32'h0;
                        status_q <= STATUS_FOUND;
                    end
                end
                default: ;
            endcase
        end
    end

    // Read path
    logic [31:0] rd_src, rd_sh;

    always_comb begin
        rd_src = 32'h0;
        if (sel_data)      rd_src = resp_q;
        else if (sel_addr) rd_src = status_q;
        rd_sh = rd_src >> {lane, 3'b000};
        unique case (io_size)
            2'd0:    io_rdata = {24'h0, rd_sh[7:0]};
            2'd1:    io_rdata = {16'h0, rd_sh[15:0]};
            default: io_rdata = rd_sh;
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign cfg_err = err_q;

    assert_quiet_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !io_wr);
    assert_match_then_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MATCH) |=> (state == ST_FETCH));
    assert_absent_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && !hit_q) |=> (resp_q == RESP_ABSENT && status_q == 32'h0));
    assert_present_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && hit_q) |=> (status_q == STATUS_FOUND));
    assert_resp_only_on_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(resp_q) |-> $past(state == ST_FETCH));
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: tb/cfg_port_decoder_test.sv
module cfg_port_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [1:0]  io_size = 2'd0;
    logic [31:0] io_wdata = 32'h0;
    logic [31:0] io_rdata;
    logic        busy;
    logic        cfg_err;

    always #5 clk = ~clk;

    cfg_port_decoder uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_size  (io_size),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .busy     (busy),
        .cfg_err  (cfg_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct packed {
        logic        wr;
        logic [15:0] a;
        logic [1:0]  sz;
        logic [31:0] d;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 53;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h0CF8, 2'd2, 32'h8000_0000, 4'd5},  // R5 fn 0000 dword0
        '{1'b0, 16'h0CFC, 2'd2, 32'h1234_ABCD, 4'd5},  // R5
        '{1'b0, 16'h0CF8, 2'd2, 32'h8000_0000, 4'd5},  // R5 status
        '{1'b0, 16'h0CFE, 2'd1, 32'h0000_1234, 4'd8},  // R8 word lane 2
        '{1'b0, 16'h0CFD, 2'd0, 32'h0000_00AB, 4'd8},  // R8 byte lane 1
        '{1'b0, 16'h0CFB, 2'd0, 32'h0000_0080, 4'd8},  // R8 status byte 3
        '{1'b0, 16'h0CF9, 2'd1, 32'h0000_0000, 4'd8},  // R8 status bytes 1..2
        '{1'b1, 16'h0CF8, 2'd2, 32'h8000_0800, 4'd2},  // R2 device 1
        '{1'b0, 16'h0CFC, 2'd2, 32'h5678_9ABC, 4'd2},  // R2
        '{1'b1, 16'h0CF8, 2'd2, 32'h8000_1000, 4'd7},  // R7 device 2 absent
        '{1'b0, 16'h0CFC, 2'd2, 32'hFFFF_FFFF, 4'd7},  // R7
        '{1'b0, 16'h0CF8, 2'd2, 32'h0000_0000, 4'd7},  // R7
        '{1'b1, 16'h0CF8, 2'd2, 32'h8001_0000, 4'd2},  // R2 bus 1
        '{1'b0, 16'h0CFC, 2'd2, 32'hFFFF_FFFF, 4'd2},  // R2
        '{1'b1, 16'h0CF8, 2'd2, 32'h8000_0100, 4'd2},  // R2 function 1
        '{1'b0, 16'h0CFC, 2'd2, 32'hFFFF_FFFF, 4'd2},  // R2
        '{1'b1, 16'h0CF8, 2'd2, 32'h0000_0000, 4'd2},  // R2 enable bit clear
        '{1'b0, 16'h0CFC, 2'd2, 32'h1234_ABCD, 4'd2},  // R2
        '{1'b1, 16'h0CF8, 2'd2, 32'h8000_0040, 4'd6},  // R6 dword 16
        '{1'b0, 16'h0CFC, 2'd2, 32'h0000_0000, 4'd6},  // R6
        '{1'b0, 16'h0CF8, 2'd2, 32'h8000_0000, 4'd6},  // R6
        '{1'b1, 16'h0CF8, 2'd2, 32'h8000_0004, 4'd9},  // R9 dword1
        '{1'b0, 16'h0CFC, 2'd2, 32'h0000_0000, 4'd9},  // R9
        '{1'b1, 16'h0CFC, 2'd2, 32'hDEAD_BEEF, 4'd9},  // R9 dword write
        '{1'b0, 16'h0CFC, 2'd2, 32'h0000_0000, 4'd9},  // R9 not refreshed
        '{1'b1, 16'h0CFB, 2'd0, 32'h0000_0080, 4'd3},  // R3 top byte only
        '{1'b0, 16'h0CFC, 2'd2, 32'hDEAD_BEEF, 4'd9},  // R9
        '{1'b1, 16'h0CFD, 2'd0, 32'h0000_0011, 4'd9},  // R9 byte lane 1
        '{1'b1, 16'h0CFB, 2'd0, 32'h0000_0080, 4'd3},  // R3
        '{1'b0, 16'h0CFC, 2'd2, 32'hDEAD_11EF, 4'd9},  // R9
        '{1'b1, 16'h0CFE, 2'd1, 32'h0000_2233, 4'd9},  // R9 word lane 2
        '{1'b1, 16'h0CFB, 2'd0, 32'h0000_0080, 4'd3},  // R3
        '{1'b0, 16'h0CFC, 2'd2, 32'h2233_11EF, 4'd9},  // R9
        '{1'b1, 16'h0CFD, 2'd1, 32'h0000_5555, 4'd10}, // R10 misaligned word
        '{1'b1, 16'h0CFB, 2'd0, 32'h0000_0080, 4'd3},  // R3
        '{1'b0, 16'h0CFC, 2'd2, 32'h2233_11EF, 4'd10}, // R10 dropped
        '{1'b1, 16'h0CF9, 2'd0, 32'h0000_0008, 4'd3},  // R3 byte 1 only
        '{1'b0, 16'h0CFC, 2'd2, 32'h2233_11EF, 4'd3},  // R3 no lookup
        '{1'b1, 16'h0CFB, 2'd0, 32'h0000_0080, 4'd3},  // R3 -> device 1 dword1
        '{1'b0, 16'h0CFC, 2'd2, 32'h0000_0000, 4'd3},  // R3
        '{1'b1, 16'h0CF8, 2'd2, 32'h8000_1004, 4'd11}, // R11 absent
        '{1'b1, 16'h0CFC, 2'd2, 32'h9999_9999, 4'd11}, // R11
        '{1'b1, 16'h0CF8, 2'd2, 32'h8000_0044, 4'd11}, // R11 dword 17
        '{1'b1, 16'h0CFC, 2'd2, 32'h7777_7777, 4'd11}, // R11
        '{1'b1, 16'h0CF8, 2'd2, 32'h8000_0004, 4'd11}, // R11
        '{1'b0, 16'h0CFC, 2'd2, 32'h2233_11EF, 4'd11}, // R11 untouched
        '{1'b0, 16'h0CFF, 2'd0, 32'h0000_0022, 4'd8},  // R8 byte lane 3
        '{1'b1, 16'h0CF8, 2'd2, 32'h8000_0804, 4'd11}, // R11
        '{1'b0, 16'h0CFC, 2'd2, 32'h0000_0000, 4'd11}, // R11 untouched
        '{1'b1, 16'h0CF4, 2'd2, 32'hFFFF_FFFF, 4'd8},  // R8 foreign port write
        '{1'b0, 16'h0CF4, 2'd2, 32'h0000_0000, 4'd8},  // R8 foreign port read
        '{1'b0, 16'h0CFC, 2'd2, 32'h0000_0000, 4'd8},  // R8 response kept
        '{1'b0, 16'h0CF8, 2'd2, 32'h8000_0000, 4'd8}   // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_write(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_size = sz; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic read_port(input logic [15:0] a, input logic [1:0] sz, output logic [31:0] v);
        @(negedge clk);
        io_addr = a; io_size = sz;
        #1 v = io_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        check("R1 busy", {31'h0, busy}, 32'h0);
        check("R1 err", {31'h0, cfg_err}, 32'h0);
        read_port(16'h0CFC, 2'd2, v); check("R1 response", v, 32'h0);
        read_port(16'h0CF8, 2'd2, v); check("R1 status", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                drive_write(VEC[i].a, VEC[i].sz, VEC[i].d);
                wait_idle();
            end else begin
                read_port(VEC[i].a, VEC[i].sz, v);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].d);
            end
        end
        check("R10 sticky after table", {31'h0, cfg_err}, 32'h1);

        // R1 second reset clears flag and storage
        do_reset();
        check("R1 err cleared", {31'h0, cfg_err}, 32'h0);
        drive_write(16'h0CF8, 2'd2, 32'h8000_0004);
        wait_idle();
        read_port(16'h0CFC, 2'd2, v); check("R1 dword1 reset", v, 32'h0);

        // R4 busy window
        @(negedge clk);
        io_wr = 1'b1; io_addr = 16'h0CF8; io_size = 2'd2; io_wdata = 32'h8000_0000;
        @(negedge clk);
        io_wr = 1'b0;
        check("R4 busy cycle 1", {31'h0, busy}, 32'h1);
        @(negedge clk);
        check("R4 busy cycle 2", {31'h0, busy}, 32'h1);
        @(negedge clk);
        check("R4 busy dropped", {31'h0, busy}, 32'h0);
        io_addr = 16'h0CFC; io_size = 2'd2;
        #1 check("R4 result ready", io_rdata, 32'h1234_ABCD);

        // R10 misaligned dword on address window: no lookup, flag set
        drive_write(16'h0CF9, 2'd2, 32'hFFFF_FFFF);
        check("R10 no lookup", {31'h0, busy}, 32'h0);
        check("R10 flag set", {31'h0, cfg_err}, 32'h1);
        read_port(16'h0CF8, 2'd2, v); check("R10 status kept", v, 32'h8000_0000);

        // R10 size code 3 after a fresh reset
        do_reset();
        drive_write(16'h0CFC, 2'd3, 32'h0);
        check("R10 size code 3", {31'h0, cfg_err}, 32'h1);
        drive_write(16'h0CFC, 2'd0, 32'h0);
        check("R10 stays set", {31'h0, cfg_err}, 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule